// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block guards a system against software that stops running. Software writes one 32-bit control word that carries a 7-bit key, a run bit and an 8-bit tick count. An accepted write reloads a down-counter and either starts or stops it. The counter advances once per tick. The tick is a one-cycle strobe from a built-in prescaler that divides the system clock down to the watchdog tick rate.

Once a stored control word has its run bit set, software can only service the watchdog with a write whose key is the bitwise inverse of the stored key. Any other write is dropped whole. If the counter runs out, the block warns first: it raises a non-maskable interrupt line and reloads a short grace count. If the grace count also runs out with no accepted write, the block emits a single-cycle system reset request and stops counting. An accepted write at any point clears the warning and starts a new period.

A small register window exposes the stored control word and a status word. Offsets are parameters, and the defaults are 0x40 for control and 0x44 for status.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, and whenever rst_n is low, nmi and rst_req are 0, the status word reads 0 and the stored control word reads 0.
- R2: A control write uses key = bits [15:9], run = bit 8 and count = bits [7:0]. An accepted write is stored, and reading the control offset returns it in bits [15:0] with bits [31:16] as zero.
- R3: While the stored run bit is 1, a control write whose key is not the 7-bit bitwise inverse of the stored key is ignored. The stored word, the status word and the expiry timing stay unchanged.
- R4: While the stored run bit is 0, a control write is accepted whatever its key.
- R5: The counter decrements on each tick, and a tick occurs every CLK_HZ/TICK_HZ clock cycles. The prescaler restarts on an accepted write. With count N, nmi rises N*DIV clock edges after the accepting edge.
- R6: A count field of 0 gives a period of 256 ticks.
- R7: At the first expiry, nmi goes to 1, the counter reloads GRACE_TICKS and keeps running, and the status reads stage 1 with running set.
- R8: At the second expiry, GRACE_TICKS*DIV edges after the first, rst_req is high for exactly one cycle. The status then reads stage 2 with running clear, and nmi stays 1.
- R9: An accepted write clears nmi and the stage and reloads the counter. It takes effect at the edge on which it is written.
- R10: An accepted write with run = 0 leaves the counter stopped, so no expiry ever follows.
- R11: The status word holds the stage (0 idle, 1 warned, 2 fired) in bits [1:0] and the running flag in bit 2. Reads of any other offset return 0. Writes to any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| nmi | output | 1 | Non-maskable interrupt, set at first expiry |
| rst_req | output | 1 | One-cycle system reset request at second expiry |

## Verification
The bench builds the block with CLK_HZ = 7600, TICK_HZ = 760 and GRACE_TICKS = 1, which makes one tick exactly ten clocks. With these values even the 256-tick period from a zero count finishes in a few thousand cycles. The bench can therefore predict every nmi edge and every reset pulse to the exact cycle as multiples of ten. The same scaling lets it place rejected and accepted writes in the middle of a count, and then confirm that expiry still lands on the predicted cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control word layout; the key must sit directly above the run bit,
    // which sits directly above the count.
    localparam int CNT_W   = 8;
    localparam int KEY_W   = 7;
    localparam int WORD_W  = KEY_W + 1 + CNT_W;

    typedef enum logic [1:0] {
        STG_IDLE  = 2'd0,
        STG_WARN  = 2'd1,
        STG_FIRED = 2'd2
    } stage_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             run;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t d, q;

    always_comb begin
        d = q;
        if (restart || q.phase == LAST) begin
            d.phase = '0;
        end else begin
            d.phase = q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = (q.phase == LAST) && !restart;

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
    import wdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  ctrl_t wr_word,
    output logic  accept,
    output ctrl_t stored
);
    typedef struct packed {
        ctrl_t word;
    } gate_t;

    gate_t d, q;

    always_comb begin
        accept = wr_hit && (!q.word.run || (wr_word.key == ~q.word.key));
        d = q;
        if (accept) d.word = wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stored = q.word;

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !accept) |=> $stable(stored));

    // R4
    open_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !stored.run) |-> accept);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int GRACE_TICKS = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   load,
    input  ctrl_t  load_word,
    output logic   nmi,
    output logic   rst_req,
    output logic   running,
    output stage_e stage
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] FULL  = CW'(1) << CNT_W;
    localparam logic [CW-1:0] GRACE = CW'(GRACE_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        stage_e        stage;
        logic          nmi;
        logic          rreq;
    } core_t;

    core_t d, q;

    always_comb begin
        d = q;
        d.rreq = 1'b0;
        if (load) begin
            d.cnt   = (load_word.cnt == '0) ? FULL : {1'b0, load_word.cnt};
            d.run   = load_word.run;
            d.stage = STG_IDLE;
            d.nmi   = 1'b0;
        end else if (q.run && tick) begin
            if (q.cnt == CW'(1)) begin
                if (q.stage == STG_IDLE) begin
                    d.stage = STG_WARN;
                    d.nmi   = 1'b1;
                    d.cnt   = GRACE;
                end else begin
                    d.stage = STG_FIRED;
                    d.rreq  = 1'b1;
                    d.run   = 1'b0;
                    d.cnt   = '0;
                end
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt   <= '0;
            q.run   <= 1'b0;
            q.stage <= STG_IDLE;
            q.nmi   <= 1'b0;
            q.rreq  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign nmi     = q.nmi;
    assign rst_req = q.rreq;
    assign running = q.run;
    assign stage   = q.stage;

    initial begin
        grace_param_chk: assert (GRACE_TICKS >= 1 && GRACE_TICKS <= 256);
    end

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rreq |=> !q.rreq);

    // R8
    rst_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rreq |-> (q.nmi && !q.run && $past(q.stage) == STG_WARN));

    // R9
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!q.nmi && q.stage == STG_IDLE));

    // R5
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.cnt != '0 && q.cnt <= FULL));

    // R7
    warn_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stage != STG_IDLE) |-> q.nmi);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int              CLK_HZ      = 50_000_000,
    parameter int              TICK_HZ     = 760,
    parameter int              GRACE_TICKS = 1,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'('h40),
    parameter logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'('h44)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              nmi,
    output logic              rst_req
);
    localparam int DIV = (CLK_HZ / TICK_HZ < 2) ? 2 : CLK_HZ / TICK_HZ;

    logic   wr_hit;
    logic   accept;
    logic   tick;
    logic   running;
    ctrl_t  wr_word;
    ctrl_t  stored;
    stage_e stage;
    logic   unused_hi;

    assign wr_hit    = wr_en && (wr_addr == CTRL_OFS);
    assign wr_word   = ctrl_t'(wr_data[WORD_W-1:0]);
    assign unused_hi = ^wr_data[31:WORD_W];

    wdt_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    wdt_key_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_word (wr_word),
        .accept  (accept),
        .stored  (stored)
    );

    wdt_core #(.GRACE_TICKS(GRACE_TICKS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (accept),
        .load_word (stored_next_word(accept, wr_word)),
        .nmi       (nmi),
        .rst_req   (rst_req),
        .running   (running),
        .stage     (stage)
    );

    function automatic ctrl_t stored_next_word(input logic acc, input ctrl_t w);
        return acc ? w : '0;
    endfunction

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_OFS) begin
            rd_data[WORD_W-1:0] = stored;
        end else if (rd_addr == STAT_OFS) begin
            rd_data[1:0] = stage;
            rd_data[2]   = running;
        end
    end

    // R11
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_OFS) |=> $stable(stored));

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    localparam int DIV   = 10;
    localparam int GRACE = 1;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_STAT = 8'h44;

    // {run, count}
    localparam logic [8:0] VEC [5] = '{9'h103, 9'h101, 9'h005, 9'h100, 9'h107};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        nmi;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    logic [6:0] bkey = '0;
    logic       ben  = 1'b0;
    logic [31:0] last_word = '0;

    always #10 clk = ~clk;

    keyed_watchdog #(
        .CLK_HZ(7600), .TICK_HZ(760), .GRACE_TICKS(GRACE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .nmi(nmi), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // valid service write; key chosen per stored state
    task automatic svc(input logic run, input logic [7:0] cnt);
        logic [6:0] k;
        k = ben ? ~bkey : 7'h2A;
        last_word = {16'hA5A5, k, run, cnt};
        wr(A_CTRL, last_word);
        bkey = k; ben = run;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        skip(3);
        rst_n = 1'b1;
        skip(1);
        // R1 reset state
        chk("R1 nmi", {31'b0, nmi}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);

        for (int i = 0; i < 5; i++) begin
            logic run;
            logic [7:0] c;
            int n;
            run = VEC[i][8];
            c   = VEC[i][7:0];
            n   = (c == 0) ? 256 : int'(c);
            svc(run, c);
            rd(A_CTRL, v); chk("R2 ctrl readback", v, {16'h0, last_word[15:0]});
            chk("R9 nmi cleared", {31'b0, nmi}, 0);
            if (run) begin
                skip(DIV * n - 1);
                chk((c == 0) ? "R6 no early nmi" : "R5 no early nmi", {31'b0, nmi}, 0);
                skip(1);
                chk((c == 0) ? "R6 nmi at 256" : "R5 nmi on time", {31'b0, nmi}, 1);
                rd(A_STAT, v); chk("R7 stage1 running", v, 32'h5);
                skip(DIV * GRACE - 1);
                chk("R8 no early rst", {31'b0, rst_req}, 0);
                skip(1);
                chk("R8 rst pulse", {31'b0, rst_req}, 1);
                rd(A_STAT, v); chk("R8 stage2 stopped", v, 32'h2);
                skip(1);
                chk("R8 pulse width", {31'b0, rst_req}, 0);
                chk("R8 nmi held", {31'b0, nmi}, 1);
            end else begin
                skip(DIV * 8);
                chk("R10 no nmi", {31'b0, nmi}, 0);
                rd(A_STAT, v); chk("R10 stopped", v, 0);
            end
        end

        // R3: wrong key while enabled is dropped
        svc(1'b1, 8'd5);
        skip(20);
        wr(A_CTRL, {16'h0, bkey, 1'b0, 8'd1});
        rd(A_CTRL, v); chk("R3 ctrl kept", v, {16'h0, last_word[15:0]});
        rd(A_STAT, v); chk("R3 status kept", v, 32'h4);
        skip(27);
        chk("R3 timing kept early", {31'b0, nmi}, 0);
        skip(1);
        chk("R3 timing kept nmi", {31'b0, nmi}, 1);

        // R9: service during warning
        svc(1'b1, 8'd2);
        chk("R9 nmi dropped", {31'b0, nmi}, 0);
        rd(A_STAT, v); chk("R9 stage cleared", v, 32'h4);
        skip(19);
        chk("R9 reload early", {31'b0, nmi}, 0);
        skip(1);
        chk("R9 reload nmi", {31'b0, nmi}, 1);

        // R4: disabled stored word accepts any key
        svc(1'b0, 8'd4);
        last_word = {16'h0, bkey, 1'b1, 8'd1};
        wr(A_CTRL, last_word);
        rd(A_CTRL, v); chk("R4 any key accepted", v, last_word);
        bkey = last_word[15:9]; ben = 1'b1;
        skip(9);
        chk("R4 early", {31'b0, nmi}, 0);
        skip(1);
        chk("R4 nmi", {31'b0, nmi}, 1);

        // R11: foreign offsets
        wr(8'h48, 32'h0000_FFFF);
        rd(A_CTRL, v); chk("R11 foreign write", v, last_word);
        rd(8'h50, v); chk("R11 foreign read", v, 0);

        // R1: reset mid-operation
        rst_n = 1'b0;
        skip(2);
        chk("R1 nmi in reset", {31'b0, nmi}, 0);
        rd(A_STAT, v); chk("R1 status in reset", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl in reset", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule